// File: doc/BRIEF.md
# Three-Stage Eight-Times Audio Interpolator

This block takes one 20-bit left/right sample pair per frame period and turns it into eight 20-bit pairs at eight times that rate. The output feeds a noise-shaping modulator. Three cascaded stages each double the rate. A stage treats its input as zero-stuffed, so each input sample yields two outputs. The first is the held sample and needs no arithmetic. The second is an interpolated value from a symmetric filter, and only the non-zero taps of that filter are evaluated. One shared pre-add/multiply/accumulate unit does every product, for all stages and both channels.

The block runs on a clock at 64 times the input frame rate. An accepted input pair starts a fixed schedule with a known cycle count. The schedule works through stage 1 (left, then right), then stage 2, then stage 3, and stores the eight results per channel. A playout unit then presents those pairs one every eight clocks, each marked by a strobe. Every stage rounds and saturates its interpolated values back to 20 bits.

Top module: `interp8x`

## Requirements
- R1: While `rst_n` is low at a clock edge and after it, `out_valid`, `out_left` and `out_right` are 0, and all filter history is cleared to zero.
- R2: A pulse on `in_valid` while a frame is being computed is ignored: that input pair never shows up in any output.
- R3: Every accepted input pair produces exactly eight output pairs, each marked by a one-cycle `out_valid`, with consecutive strobes of a frame exactly 8 clocks apart.
- R4: The first output pair of a frame appears 54 clocks after the edge that accepted its input, and the computation of a frame ends within 64 clocks.
- R5: Each stage keeps a per-channel history line d[0..2P-1], with d[0] newest, that shifts once per stage input. For each input it emits two samples in this order: d[P], then round(sum over k of c[k]*(d[P-1-k]+d[P+k])).
- R6: The tap counts P are 4, 2 and 1 for stages 1, 2 and 3. The coefficients, scaled by 2^16, are {39200, -7840, 1568, -160}, {36864, -4096} and {32768}.
- R7: The interpolated value is (acc + 2^15) arithmetically shifted right by 16, then clamped to [-524288, 524287].
- R8: A constant input that has filled every history line gives outputs equal to that constant.
- R9: The two channels are independent: a channel held at zero from reset outputs only zeros, whatever the other channel carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 64 times the input frame rate |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | One-cycle strobe marking a new input pair |
| in_left | input | 20 | Left input sample, two's complement |
| in_right | input | 20 | Right input sample, two's complement |
| out_valid | output | 1 | One-cycle strobe marking an output pair |
| out_left | output | 20 | Left output sample at eight times the input rate |
| out_right | output | 20 | Right output sample at eight times the input rate |

## Verification
Some properties are checked on every cycle by the assertions. These are the 64-clock bound on a frame's schedule, the frozen input latch while a frame is in flight, the accumulator clearing before each new sum, and the minimum spacing of output strobes. The arithmetic itself is shown only by the bench's scenarios, which compare every output pair against a software model of the three stages: tap order, coefficient values, rounding and saturation, unity DC gain and channel isolation. The same scenarios cover the exact 54-clock latency, the eight-per-frame output count, and the rejection of an input strobe that arrives in mid-frame.

// File: rtl/interp_pkg.sv
// Shared constants and coefficient set for the eight-times interpolator.
// Assumes three stages, two channels and at most four non-zero tap pairs.
package interp_pkg;
    localparam int NSTAGE = 3;
    localparam int NCH    = 2;
    localparam int MAXP   = 4;
    localparam int MAXLEN = 2 * MAXP;
    localparam int OUTPH  = 1 << NSTAGE;
    localparam int STG_W  = $clog2(NSTAGE);
    localparam int CH_W   = $clog2(NCH);
    localparam int M_W    = NSTAGE - 1;
    localparam int PH_W   = $clog2(MAXP + 2);
    localparam int TAP_W  = $clog2(MAXP);
    localparam int LEN_W  = $clog2(MAXLEN);
    localparam int OUT_W  = $clog2(OUTPH);

    // Non-zero tap pairs per stage (stage 0 is the first, longest filter).
    function automatic int stage_taps(input int s);
        case (s)
            0:       return 4;
            1:       return 2;
            default: return 1;
        endcase
    endfunction

    // Coefficient k of stage s, scaled by 2^16; each set sums to 2^15.
    function automatic int stage_coef(input int s, input int k);
        if (s == 0) begin
            case (k)
                0:       return 39200;
                1:       return -7840;
                2:       return 1568;
                default: return -160;
            endcase
        end else if (s == 1) begin
            return (k == 0) ? 36864 : -4096;
        end
        return 32768;
    endfunction
endpackage

// File: rtl/interp_seq.sv
// Operation sequencer: walks stage, channel, sample and phase so that the one
// shared arithmetic unit serves every stage and channel.
// Phases per stage input: load (shift history), P multiply steps, write.
// Assumes input strobes arrive no more often than once per FRAME_CYC clocks.
module interp_seq
    import interp_pkg::*;
#(
    parameter int FRAME_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    output logic             accept,
    output logic             busy,
    output logic [STG_W-1:0] stg,
    output logic [CH_W-1:0]  ch,
    output logic [M_W-1:0]   m,
    output logic [TAP_W-1:0] tap,
    output logic             ph_load,
    output logic             ph_mac,
    output logic             ph_write,
    output logic             done
);
    localparam int BC_W = $clog2(FRAME_CYC + 1);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] p_cur;
    logic [M_W-1:0]  m_last;
    logic            last_op;

    // Decode the current phase against the active stage's tap count.
    always_comb begin
        p_cur    = PH_W'(stage_taps(int'(stg)));
        m_last   = M_W'((1 << stg) - 1);
        accept   = start_req && !busy;
        ph_load  = busy && (ph == '0);
        ph_mac   = busy && (ph != '0) && (ph <= p_cur);
        ph_write = busy && (ph == p_cur + PH_W'(1));
        tap      = TAP_W'(ph - PH_W'(1));
        last_op  = ph_write && (m == m_last) && (ch == CH_W'(NCH - 1))
                   && (stg == STG_W'(NSTAGE - 1));
    end

    // Advance phase, sample, channel and stage counters in nested order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            stg  <= '0;
            ch   <= '0;
            m    <= '0;
            ph   <= '0;
        end else if (!busy) begin
            if (start_req) begin
                busy <= 1'b1;
                stg  <= '0;
                ch   <= '0;
                m    <= '0;
                ph   <= '0;
            end
        end else if (!ph_write) begin
            ph <= ph + PH_W'(1);
        end else begin
            ph <= '0;
            if (m != m_last) begin
                m <= m + M_W'(1);
            end else begin
                m <= '0;
                if (ch != CH_W'(NCH - 1)) begin
                    ch <= ch + CH_W'(1);
                end else begin
                    ch <= '0;
                    if (stg != STG_W'(NSTAGE - 1)) stg <= stg + STG_W'(1);
                    else busy <= 1'b0;
                end
            end
        end
    end

    // Register the end-of-frame pulse so the final write lands first.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= last_op;
    end

    // Count busy cycles for the schedule-budget check.
    logic [BC_W-1:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_cnt <= '0;
        else                 busy_cnt <= busy_cnt + BC_W'(1);
    end

    assert_frame_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < BC_W'(FRAME_CYC)));
endmodule

// File: rtl/interp_mac.sv
// Shared arithmetic unit: pre-adds a symmetric tap pair, multiplies by the
// coefficient and accumulates; rounds and saturates the sum to DW bits.
// Assumes clr and en are never raised together.
module interp_mac #(
    parameter int DW   = 20,
    parameter int CW   = 18,
    parameter int FRAC = 16,
    parameter int AW   = 44
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    input  logic signed [CW-1:0] coef,
    output logic signed [DW-1:0] res
);
    localparam logic signed [AW-1:0] HALF =
        {{(AW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [AW-1:0] LO = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW:0]    pre;
    logic signed [DW+CW:0] prod;
    logic signed [AW-1:0]  acc;
    logic signed [AW-1:0]  shifted;

    // Pre-add the mirrored taps and form the product.
    always_comb begin
        pre  = {a[DW-1], a} + {b[DW-1], b};
        prod = pre * coef;
    end

    // Clear at the start of each sum, accumulate on multiply steps.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc <= '0;
        else if (en)       acc <= acc + AW'(prod);
    end

    // Round half up, drop the fraction, clamp to the output range.
    always_comb begin
        shifted = (acc + HALF) >>> FRAC;
        if (shifted > HI)      res = HI[DW-1:0];
        else if (shifted < LO) res = LO[DW-1:0];
        else                   res = shifted[DW-1:0];
    end

    assert_acc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    assert_ctrl_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && en));
endmodule

// File: rtl/interp_emit.sv
// Output playout: captures a frame's NOUT results and presents one pair every
// SPACING clocks, with a one-cycle strobe.
// Assumes a new load arrives no sooner than NOUT*SPACING clocks after the last.
module interp_emit #(
    parameter int DW      = 20,
    parameter int NOUT    = 8,
    parameter int SPACING = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NOUT-1:0][DW-1:0]   frame_l,
    input  logic [NOUT-1:0][DW-1:0]   frame_r,
    output logic                      out_valid,
    output logic signed [DW-1:0]      out_l,
    output logic signed [DW-1:0]      out_r
);
    localparam int IW   = $clog2(NOUT);
    localparam int DV_W = $clog2(SPACING);
    localparam int GW   = $clog2(SPACING + 1);

    logic [NOUT-1:0][DW-1:0] hold_l;
    logic [NOUT-1:0][DW-1:0] hold_r;
    logic [IW-1:0]           idx;
    logic [DV_W-1:0]         div;
    logic                    active;

    // Capture a frame, then step through it at the output rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l    <= '0;
            hold_r    <= '0;
            idx       <= '0;
            div       <= '0;
            active    <= 1'b0;
            out_valid <= 1'b0;
            out_l     <= '0;
            out_r     <= '0;
        end else if (load) begin
            hold_l    <= frame_l;
            hold_r    <= frame_r;
            idx       <= '0;
            div       <= '0;
            active    <= 1'b1;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (active) begin
                div <= (div == DV_W'(SPACING - 1)) ? '0 : div + DV_W'(1);
                if (div == '0) begin
                    out_l     <= hold_l[idx];
                    out_r     <= hold_r[idx];
                    out_valid <= 1'b1;
                    idx       <= idx + IW'(1);
                    if (idx == IW'(NOUT - 1)) active <= 1'b0;
                end
            end
        end
    end

    // Track idle cycles since the last strobe for the spacing check.
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n)          gap <= GW'(SPACING);
        else if (out_valid)  gap <= '0;
        else if (gap != GW'(SPACING)) gap <= gap + GW'(1);
    end

    assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (gap >= GW'(SPACING - 1)));
endmodule

// File: rtl/interp8x.sv
// Eight-times interpolator top: three rate-doubling stages sharing one
// arithmetic unit, per-stage history lines and result buffers, and playout.
// Assumes a clock at FRAME_CYC times the input rate and one strobe per frame.
module interp8x
    import interp_pkg::*;
#(
    parameter int DW        = 20,
    parameter int CW        = 18,
    parameter int FRAC      = 16,
    parameter int AW        = 44,
    parameter int FRAME_CYC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_left,
    input  logic signed [DW-1:0] in_right,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_left,
    output logic signed [DW-1:0] out_right
);
    localparam int SPACING = FRAME_CYC / OUTPH;

    logic             accept, busy, ph_load, ph_mac, ph_write, done;
    logic [STG_W-1:0] stg;
    logic [CH_W-1:0]  ch;
    logic [M_W-1:0]   m;
    logic [TAP_W-1:0] tap;

    logic signed [DW-1:0] lat   [NCH];
    logic signed [DW-1:0] hist  [NSTAGE][NCH][MAXLEN];
    logic signed [DW-1:0] stbuf [NSTAGE][NCH][OUTPH];

    logic signed [DW-1:0] src, mac_a, mac_b, mac_res, even_smp;
    logic signed [CW-1:0] mac_c;
    logic [STG_W-1:0]     prev_stg;
    logic [LEN_W-1:0]     ia, ib, ip;
    logic [OUT_W-1:0]     wr_even, wr_odd;

    interp_seq #(.FRAME_CYC(FRAME_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(in_valid), .accept(accept),
        .busy(busy), .stg(stg), .ch(ch), .m(m), .tap(tap),
        .ph_load(ph_load), .ph_mac(ph_mac), .ph_write(ph_write), .done(done)
    );

    interp_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .AW(AW)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(ph_load), .en(ph_mac),
        .a(mac_a), .b(mac_b), .coef(mac_c), .res(mac_res)
    );

    // Select the stage input, the mirrored tap pair and the coefficient.
    always_comb begin
        int p;
        p        = stage_taps(int'(stg));
        prev_stg = (stg == '0) ? '0 : stg - STG_W'(1);
        src      = (stg == '0) ? lat[ch] : stbuf[prev_stg][ch][OUT_W'(m)];
        ia       = LEN_W'(p - 1 - int'(tap));
        ib       = LEN_W'(p + int'(tap));
        ip       = LEN_W'(p);
        mac_a    = hist[stg][ch][ia];
        mac_b    = hist[stg][ch][ib];
        mac_c    = CW'(stage_coef(int'(stg), int'(tap)));
        even_smp = hist[stg][ch][ip];
        wr_even  = OUT_W'({m, 1'b0});
        wr_odd   = OUT_W'({m, 1'b1});
    end

    // Latch the input pair when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) lat[c] <= '0;
        end else if (accept) begin
            lat[0] <= in_left;
            lat[1] <= in_right;
        end
    end

    // Shift the active history line on load; store both results on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTAGE; s++)
                for (int c = 0; c < NCH; c++) begin
                    for (int i = 0; i < MAXLEN; i++) hist[s][c][i] <= '0;
                    for (int j = 0; j < OUTPH; j++)  stbuf[s][c][j] <= '0;
                end
        end else begin
            if (ph_load) begin
                hist[stg][ch][0] <= src;
                for (int i = 1; i < MAXLEN; i++)
                    hist[stg][ch][i] <= hist[stg][ch][i-1];
            end
            if (ph_write) begin
                stbuf[stg][ch][wr_even] <= even_smp;
                stbuf[stg][ch][wr_odd]  <= mac_res;
            end
        end
    end

    logic [OUTPH-1:0][DW-1:0] fr_l, fr_r;
    for (genvar j = 0; j < OUTPH; j++) begin : g_frame
        assign fr_l[j] = stbuf[NSTAGE-1][0][j];
        assign fr_r[j] = stbuf[NSTAGE-1][1][j];
    end

    interp_emit #(.DW(DW), .NOUT(OUTPH), .SPACING(SPACING)) u_emit (
        .clk(clk), .rst_n(rst_n), .load(done), .frame_l(fr_l), .frame_r(fr_r),
        .out_valid(out_valid), .out_l(out_left), .out_r(out_right)
    );

    assert_ignore_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy) |=> ($stable(lat[0]) && $stable(lat[1])));
    assert_quiet_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !busy));
endmodule

// File: tb/interp8x_bench.sv
// Bench: directed corner cases plus seeded random frames, checked against a
// software model of the three stages written from the requirements.
module interp8x_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [19:0] in_left = '0, in_right = '0;
    logic out_valid;
    logic signed [19:0] out_left, out_right;

    int checks = 0, errors = 0;
    int cyc = 0, last_cyc = 0, out_count = 0, frames = 0, sat_seen = 0;
    bit right_zero = 1'b0, dc_mode = 1'b0, finished = 1'b0;
    int dc_val = 0;

    int mh  [3][2][8];
    int mbf [3][2][8];
    int exp_l[$], exp_r[$], acc_cyc[$];

    interp8x u_interp8x (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int taps_of(input int s);
        return (s == 0) ? 4 : (s == 1) ? 2 : 1;
    endfunction

    function automatic int coef_of(input int s, input int k);
        int c0[4] = '{39200, -7840, 1568, -160};
        int c1[2] = '{36864, -4096};
        if (s == 0) return c0[k];
        if (s == 1) return c1[k];
        return 32768;
    endfunction

    function automatic int rsat(input longint acc);
        longint t;
        t = (acc + 64'sd32768) >>> 16;
        if (t > 524287)  return 524287;
        if (t < -524288) return -524288;
        return int'(t);
    endfunction

    function automatic int rnd20();
        logic [19:0] v;
        v = 20'($urandom);
        return int'($signed(v));
    endfunction

    // Model one accepted frame (R5, R6, R7) and queue its eight pairs.
    task automatic model_frame(input int l, input int r);
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 2; c++)
                for (int mi = 0; mi < (1 << s); mi++) begin
                    int p, src;
                    longint acc;
                    p   = taps_of(s);
                    src = (s == 0) ? ((c == 0) ? l : r) : mbf[s-1][c][mi];
                    for (int i = 7; i > 0; i--) mh[s][c][i] = mh[s][c][i-1];
                    mh[s][c][0] = src;
                    acc = 0;
                    for (int k = 0; k < p; k++)
                        acc += longint'(coef_of(s, k)) *
                               longint'(mh[s][c][p-1-k] + mh[s][c][p+k]);
                    mbf[s][c][2*mi]   = mh[s][c][p];
                    mbf[s][c][2*mi+1] = rsat(acc);
                end
        for (int j = 0; j < 8; j++) begin
            exp_l.push_back(mbf[2][0][j]);
            exp_r.push_back(mbf[2][1][j]);
        end
    endtask

    // Drive one frame over 64 clocks; optionally add a mid-frame strobe (R2).
    task automatic send_frame(input int l, input int r, input bit spur);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = 20'(l);
        in_right = 20'(r);
        acc_cyc.push_back(cyc + 1);
        model_frame(l, r);
        frames++;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (9) @(negedge clk);
        if (spur) begin
            in_valid = 1'b1;
            in_left  = ~in_left;
            in_right = 20'(12345);
            @(negedge clk);
            in_valid = 1'b0;
            repeat (52) @(negedge clk);
        end else begin
            repeat (53) @(negedge clk);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Compare every strobed pair against the model; check timing (R3, R4).
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            int el, er;
            if (exp_l.size() == 0) begin
                check(1'b0, "R3", "unexpected output pair", out_count, -1);
            end else begin
                el = exp_l.pop_front();
                er = exp_r.pop_front();
                if (el == 524287 || el == -524288 || er == 524287 || er == -524288)
                    sat_seen++;
                check(int'(out_left) == el, "R5 R7", "left sample", int'(out_left), el);
                check(int'(out_right) == er, "R5 R7", "right sample", int'(out_right), er);
                if (right_zero) check(out_right == '0, "R9", "idle right channel",
                                      int'(out_right), 0);
                if (dc_mode) check(int'(out_left) == dc_val, "R8", "DC gain",
                                   int'(out_left), dc_val);
            end
            if (out_count % 8 == 0) begin
                if (acc_cyc.size() != 0) begin
                    int a;
                    a = acc_cyc.pop_front();
                    check(cyc - a == 54, "R4", "latency", cyc - a, 54);
                end
            end else begin
                check(cyc - last_cyc == 8, "R3", "strobe spacing", cyc - last_cyc, 8);
            end
            last_cyc = cyc;
            out_count++;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int sat_pat[8] = '{-524288, 524287, -524288, 524287,
                           524287, -524288, 524287, -524288};
        void'($urandom(32'd20031));
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 8; i++) begin
                    mh[s][c][i] = 0;
                    mbf[s][c][i] = 0;
                end

        repeat (5) @(negedge clk);
        // R1: outputs quiet while and after reset.
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(out_left == '0, "R1", "out_left after reset", int'(out_left), 0);
        check(out_right == '0, "R1", "out_right after reset", int'(out_right), 0);

        // R9: right channel zero from reset, left random.
        right_zero = 1'b1;
        for (int f = 0; f < 12; f++) send_frame(rnd20(), 0, 1'b0);

        // R7: alternating full-scale pattern that overshoots the range.
        right_zero = 1'b0;
        for (int rep = 0; rep < 2; rep++)
            for (int i = 0; i < 8; i++) send_frame(sat_pat[i], sat_pat[7-i], 1'b0);

        // R8: settled constant input.
        dc_val = 123456;
        for (int f = 0; f < 20; f++) begin
            if (f == 15) dc_mode = 1'b1;
            send_frame(dc_val, -dc_val, 1'b0);
        end
        dc_mode = 1'b0;

        // R2: random frames, every fourth with a mid-frame strobe to ignore.
        for (int f = 0; f < 40; f++) send_frame(rnd20(), rnd20(), (f % 4) == 1);

        repeat (200) @(negedge clk);
        check(out_count == 8 * frames, "R2 R3", "total output pairs", out_count, 8 * frames);
        check(sat_seen > 0, "R7", "saturated values observed", sat_seen, 1);
        check(exp_l.size() == 0, "R3", "pairs left unseen", exp_l.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule